// File: doc/BRIEF.md
# SPI Controller Host Register and Interrupt Front-End

This block is the software-facing register file of a command-driven SPI controller. A host issues 32-bit reads and writes on a simple valid/ready register port. The block decodes them at fixed byte offsets. Writes at two offsets are turned into pushes into an external command FIFO and an external transmit-data FIFO. Reads at two other offsets take the head word of an external receive-data FIFO. One of those reads pops the word and the other only looks at it. Status registers report the free space of the two outbound FIFOs and the fill level of the inbound one.

An interrupt group joins three FIFO threshold conditions with a completion event that the SPI sequencer raises when it finishes a sync instruction. The sequencer also supplies an 8-bit tag, which the block latches. The group has enable, pending and source views, and drives one interrupt line. A one-bit soft-reset register holds the downstream engine in reset.

The FIFOs and the sequencer sit outside the block. The FIFOs are first-word-fallthrough and are seen only through push, pop, head, room and level ports.

Top module: `spi_hostregs`

## Requirements
- R1: After the synchronous active-low reset, every register reads 0, `irq` is 0 and `engine_reset` is 0.
- R2: A read at any offset not listed in these requirements returns 0. The enable register at 0x80 keeps bits 3:0 of the written value and reads back with its upper bits 0.
- R3: A write at 0xE0 pushes bits 15:0 of the write data into the command FIFO when `cmd_room` is nonzero. A write at 0xE4 pushes all 32 bits into the transmit FIFO when `tx_room` is nonzero. When the room is zero, no push happens and a sticky overflow flag is set. The flag reads as bit 31 of 0xD0 for the command FIFO and bit 31 of 0xD4 for the transmit FIFO.
- R4: 0xD0 returns `cmd_room`, 0xD4 returns `tx_room` and 0xD8 returns `rx_level`, each zero-extended in the low bits.
- R5: A read at 0xE8 returns `rx_head` and pulses `rx_pop` once when `rx_level` is nonzero. When `rx_level` is zero, the read returns 0 and does not pop.
- R6: A read at 0xEC returns `rx_head` when `rx_level` is nonzero, and 0 otherwise. It never pops.
- R7: A cycle with `sync_valid` high latches `sync_tag` into the register at 0xC0 and sets pending bit 3.
- R8: Writing to 0x84 clears every pending bit written as 1, so 0xFF clears all of them. A sync event in the same cycle as a clear of bit 3 leaves bit 3 set.
- R9: Pending bit 0 is set while `cmd_room >= CMD_AE_ROOM`, bit 1 is set while `tx_room >= TX_AE_ROOM`, and bit 2 is set while `rx_level >= RX_AF_LEVEL`. Each of these bits is set again on the next clock edge if its condition still holds after a clear. It stays clear once cleared while its condition is false.
- R10: 0x88 returns the pending bits ANDed with the enable bits. `irq` is 1 exactly when that value is nonzero.
- R11: Bit 0 of a write to 0x40 sets `engine_reset`, and the register reads back at 0x40. Writing 1 also clears both overflow flags.
- R12: `req_ready` is always 1. A read accepted in one cycle gives `rsp_valid` high with `rsp_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| cmd_push | output | 1 | Push into the command FIFO |
| cmd_push_data | output | CMD_W | Command word |
| cmd_room | input | LVL_W | Free entries in the command FIFO |
| tx_push | output | 1 | Push into the transmit FIFO |
| tx_push_data | output | DATA_W | Transmit word |
| tx_room | input | LVL_W | Free entries in the transmit FIFO |
| rx_pop | output | 1 | Pop from the receive FIFO |
| rx_head | input | DATA_W | Head word of the receive FIFO |
| rx_level | input | LVL_W | Words held in the receive FIFO |
| sync_valid | input | 1 | Sequencer finished a sync instruction |
| sync_tag | input | 8 | Tag of that sync instruction |
| engine_reset | output | 1 | Holds the SPI engine in reset |
| irq | output | 1 | Interrupt request |

## Verification
A pending or enable bit stored in the wrong state shows on `irq` in the same cycle. It also appears in the next read of 0x84 or 0x88. A lost clear or a lost re-set of a level-driven bit shows up one edge after the FIFO status input changes. Decode faults show at the push and pop strobes in the same cycle as the request, for example a peek that pops or a push into a full FIFO. Mux faults show in `rsp_rdata` one cycle after the read. A lost overflow flag shows only through bit 31 of the room registers, so those registers are read both before and after the reset-register clear.

// File: rtl/spi_hostregs_pkg.sv
// Package: shared register indices, offsets and interrupt bit positions.
// Assumes offsets fit in 8 bits; the decoder zero-extends them to ADDR_W.
package spi_hostregs_pkg;

    localparam int NREG  = 12;
    localparam int IRQ_N = 4;

    // interrupt bit positions (software-visible)
    localparam int IB_CMD_LOW = 0;
    localparam int IB_TX_LOW  = 1;
    localparam int IB_RX_HIGH = 2;
    localparam int IB_SYNC    = 3;

    // register indices used by the decoder's one-hot hit vectors
    localparam int RI_ENGRST = 0;
    localparam int RI_IEN    = 1;
    localparam int RI_IPEND  = 2;
    localparam int RI_ISRC   = 3;
    localparam int RI_TAG    = 4;
    localparam int RI_CROOM  = 5;
    localparam int RI_TROOM  = 6;
    localparam int RI_RLVL   = 7;
    localparam int RI_CMD    = 8;
    localparam int RI_TXD    = 9;
    localparam int RI_RXD    = 10;
    localparam int RI_PEEK   = 11;

    // byte offset of each register index
    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            RI_ENGRST: return 8'h40;
            RI_IEN:    return 8'h80;
            RI_IPEND:  return 8'h84;
            RI_ISRC:   return 8'h88;
            RI_TAG:    return 8'hC0;
            RI_CROOM:  return 8'hD0;
            RI_TROOM:  return 8'hD4;
            RI_RLVL:   return 8'hD8;
            RI_CMD:    return 8'hE0;
            RI_TXD:    return 8'hE4;
            RI_RXD:    return 8'hE8;
            RI_PEEK:   return 8'hEC;
            default:   return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_hostregs_decode.sv
// Address decoder: turns one register request into one-hot write and read
// hit vectors, one bit per register index. Assumes ADDR_W >= 8.
module spi_hostregs_decode
    import spi_hostregs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [NREG-1:0]   wr_hit,
    output logic [NREG-1:0]   rd_hit
);

    // one comparator per register offset
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        logic match;
        assign match     = (req_addr == ADDR_W'(reg_offset(i)));
        assign wr_hit[i] = req_valid &&  req_write && match;
        assign rd_hit[i] = req_valid && !req_write && match;
    end

endmodule

// File: rtl/spi_hostregs_pushgate.sv
// Push gate for one outbound FIFO: forwards a write as a push when the FIFO
// has room, otherwise drops it and sets a sticky overflow flag.
// Assumes room is the FIFO's free-entry count for the current cycle.
module spi_hostregs_pushgate #(
    parameter int DATA_W = 32,
    parameter int W      = 16,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LVL_W-1:0]  room,
    input  logic              clr_ovf,
    output logic              push,
    output logic [W-1:0]      push_data,
    output logic              overflow
);

    logic has_room;

    // push only into a FIFO that has a free entry
    assign has_room  = (room != '0);
    assign push      = wr_stb && has_room;
    assign push_data = wdata[W-1:0];

    // sticky overflow flag; a clear has priority over a new overflow
    always_ff @(posedge clk) begin
        if (!rst_n)                  overflow <= 1'b0;
        else if (clr_ovf)            overflow <= 1'b0;
        else if (wr_stb && !has_room) overflow <= 1'b1;
    end

endmodule

// File: rtl/spi_hostregs_irq.sv
// Interrupt group: enable register, pending bits and masked source.
// Triggers set their pending bit every cycle they are high; a write-1 clear
// loses to a trigger in the same cycle. Level conditions therefore re-set.
module spi_hostregs_irq
    import spi_hostregs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_N-1:0] trig,
    input  logic [IRQ_N-1:0] clr_mask,
    input  logic             en_we,
    input  logic [IRQ_N-1:0] en_wdata,
    output logic [IRQ_N-1:0] pend,
    output logic [IRQ_N-1:0] en,
    output logic [IRQ_N-1:0] src,
    output logic             irq
);

    // enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= en_wdata;
    end

    // pending bits, one register per source
    for (genvar b = 0; b < IRQ_N; b++) begin : g_pend
        always_ff @(posedge clk) begin
            if (!rst_n) pend[b] <= 1'b0;
            else        pend[b] <= (pend[b] && !clr_mask[b]) || trig[b];
        end
    end

    assign src = pend & en;
    assign irq = |src;

endmodule

// File: rtl/spi_hostregs.sv
// Host register front-end of a command-driven SPI controller.
// Decodes 32-bit register accesses, gates pushes into the command and
// transmit FIFOs, pops or peeks the receive FIFO, and runs the interrupt
// group. Assumes first-word-fallthrough FIFOs outside the block and a
// single-cycle sync pulse from the sequencer. Read data returns one cycle
// after the request; requests are always accepted.
module spi_hostregs
    import spi_hostregs_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CMD_W       = 16,
    parameter int LVL_W       = 8,
    parameter int TAG_W       = 8,
    parameter int CMD_AE_ROOM = 8,
    parameter int TX_AE_ROOM  = 8,
    parameter int RX_AF_LEVEL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cmd_push,
    output logic [CMD_W-1:0]  cmd_push_data,
    input  logic [LVL_W-1:0]  cmd_room,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_push_data,
    input  logic [LVL_W-1:0]  tx_room,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_head,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              sync_valid,
    input  logic [TAG_W-1:0]  sync_tag,
    output logic              engine_reset,
    output logic              irq
);

    localparam int MSB = DATA_W - 1;

    logic [NREG-1:0]   wr_hit;
    logic [NREG-1:0]   rd_hit;
    logic [TAG_W-1:0]  tag_q;
    logic              clr_ovf;
    logic              cmd_ovf;
    logic              tx_ovf;
    logic              rx_nonempty;
    logic [IRQ_N-1:0]  trig;
    logic [IRQ_N-1:0]  clr_mask;
    logic [IRQ_N-1:0]  pend;
    logic [IRQ_N-1:0]  en;
    logic [IRQ_N-1:0]  src;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rx_word;

    assign req_ready = 1'b1;

    spi_hostregs_decode #(.ADDR_W(ADDR_W)) u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .wr_hit    (wr_hit),
        .rd_hit    (rd_hit)
    );

    // a write of 1 to the engine reset register also clears overflow flags
    assign clr_ovf = wr_hit[RI_ENGRST] && req_wdata[0];

    spi_hostregs_pushgate #(.DATA_W(DATA_W), .W(CMD_W), .LVL_W(LVL_W)) u_cmd_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_hit[RI_CMD]),
        .wdata     (req_wdata),
        .room      (cmd_room),
        .clr_ovf   (clr_ovf),
        .push      (cmd_push),
        .push_data (cmd_push_data),
        .overflow  (cmd_ovf)
    );

    spi_hostregs_pushgate #(.DATA_W(DATA_W), .W(DATA_W), .LVL_W(LVL_W)) u_tx_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_hit[RI_TXD]),
        .wdata     (req_wdata),
        .room      (tx_room),
        .clr_ovf   (clr_ovf),
        .push      (tx_push),
        .push_data (tx_push_data),
        .overflow  (tx_ovf)
    );

    // receive FIFO: pop only on a data read of a nonempty FIFO
    assign rx_nonempty = (rx_level != '0);
    assign rx_pop      = rd_hit[RI_RXD] && rx_nonempty;
    assign rx_word     = rx_nonempty ? rx_head : '0;

    // interrupt triggers: three level conditions and the sync event
    always_comb begin
        trig             = '0;
        trig[IB_CMD_LOW] = (cmd_room >= LVL_W'(CMD_AE_ROOM));
        trig[IB_TX_LOW]  = (tx_room  >= LVL_W'(TX_AE_ROOM));
        trig[IB_RX_HIGH] = (rx_level >= LVL_W'(RX_AF_LEVEL));
        trig[IB_SYNC]    = sync_valid;
    end

    assign clr_mask = wr_hit[RI_IPEND] ? req_wdata[IRQ_N-1:0] : '0;

    spi_hostregs_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .clr_mask (clr_mask),
        .en_we    (wr_hit[RI_IEN]),
        .en_wdata (req_wdata[IRQ_N-1:0]),
        .pend     (pend),
        .en       (en),
        .src      (src),
        .irq      (irq)
    );

    // engine soft-reset register
    always_ff @(posedge clk) begin
        if (!rst_n)                 engine_reset <= 1'b0;
        else if (wr_hit[RI_ENGRST]) engine_reset <= req_wdata[0];
    end

    // last sync tag register
    always_ff @(posedge clk) begin
        if (!rst_n)          tag_q <= '0;
        else if (sync_valid) tag_q <= sync_tag;
    end

    // read data selection; hits are one-hot, unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        if (rd_hit[RI_ENGRST]) rd_mux = DATA_W'(engine_reset);
        if (rd_hit[RI_IEN])    rd_mux = DATA_W'(en);
        if (rd_hit[RI_IPEND])  rd_mux = DATA_W'(pend);
        if (rd_hit[RI_ISRC])   rd_mux = DATA_W'(src);
        if (rd_hit[RI_TAG])    rd_mux = DATA_W'(tag_q);
        if (rd_hit[RI_CROOM])  rd_mux = DATA_W'(cmd_room) | (DATA_W'(cmd_ovf) << MSB);
        if (rd_hit[RI_TROOM])  rd_mux = DATA_W'(tx_room)  | (DATA_W'(tx_ovf)  << MSB);
        if (rd_hit[RI_RLVL])   rd_mux = DATA_W'(rx_level);
        if (rd_hit[RI_RXD])    rd_mux = rx_word;
        if (rd_hit[RI_PEEK])   rd_mux = rx_word;
    end

    // registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            rsp_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/spi_hostregs_chk.sv
// Checker for spi_hostregs, bound into every instance of the top module.
// Observes ports plus the tag register, pending bits and overflow flag.
module spi_hostregs_chk #(
    parameter int ADDR_W = 8,
    parameter int LVL_W  = 8,
    parameter int TAG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_wdata0,
    input logic              rsp_valid,
    input logic              cmd_push,
    input logic [LVL_W-1:0]  cmd_room,
    input logic              rx_pop,
    input logic [LVL_W-1:0]  rx_level,
    input logic              sync_valid,
    input logic [TAG_W-1:0]  sync_tag,
    input logic [TAG_W-1:0]  tag_q,
    input logic              pend_sync,
    input logic              cmd_ovf
);

    // R3: never push into a full command FIFO
    a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |-> (cmd_room != '0));

    // R5: never pop an empty receive FIFO
    a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_level != '0));

    // R6: a peek read never pops
    a_r6_peek_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADDR_W'(8'hEC)) |-> !rx_pop);

    // R7: a sync event sets pending bit 3 and latches its tag
    a_r7_sync_pend: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> pend_sync);
    a_r7_sync_tag: assert property (@(posedge clk) disable iff (!rst_n)
        sync_valid |=> (tag_q == $past(sync_tag)));

    // R11: the overflow flag stays set until a reset-register write of 1
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ovf && !(req_valid && req_write && req_addr == ADDR_W'(8'h40) && req_wdata0))
        |=> cmd_ovf);

    // R12: always ready, read response one cycle later
    a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
    a_r12_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

endmodule

bind spi_hostregs spi_hostregs_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_wdata0 (req_wdata[0]),
    .rsp_valid  (rsp_valid),
    .cmd_push   (cmd_push),
    .cmd_room   (cmd_room),
    .rx_pop     (rx_pop),
    .rx_level   (rx_level),
    .sync_valid (sync_valid),
    .sync_tag   (sync_tag),
    .tag_q      (tag_q),
    .pend_sync  (pend[3]),
    .cmd_ovf    (cmd_ovf)
);

// File: tb/spi_hostregs_tb_top.sv
// Directed bench for spi_hostregs: one task per scenario.
module spi_hostregs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        cmd_push;
    logic [15:0] cmd_push_data;
    logic [7:0]  cmd_room = '0;
    logic        tx_push;
    logic [31:0] tx_push_data;
    logic [7:0]  tx_room = '0;
    logic        rx_pop;
    logic [31:0] rx_head = '0;
    logic [7:0]  rx_level = '0;
    logic        sync_valid = 1'b0;
    logic [7:0]  sync_tag = '0;
    logic        engine_reset;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cmd_pushes = 0;
    int tx_pushes = 0;
    int pops = 0;
    logic [15:0] last_cmd = '0;
    logic [31:0] last_tx = '0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    spi_hostregs dut_i (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .cmd_push (cmd_push), .cmd_push_data (cmd_push_data), .cmd_room (cmd_room),
        .tx_push (tx_push), .tx_push_data (tx_push_data), .tx_room (tx_room),
        .rx_pop (rx_pop), .rx_head (rx_head), .rx_level (rx_level),
        .sync_valid (sync_valid), .sync_tag (sync_tag),
        .engine_reset (engine_reset), .irq (irq)
    );

    // count the strobes the external FIFOs would see
    always @(posedge clk) begin
        if (cmd_push) begin cmd_pushes <= cmd_pushes + 1; last_cmd <= cmd_push_data; end
        if (tx_push)  begin tx_pushes  <= tx_pushes + 1;  last_tx  <= tx_push_data;  end
        if (rx_pop)   pops <= pops + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        reg_read(8'h40, rd); check("R1 engine reset reg", rd, 0);
        reg_read(8'h80, rd); check("R1 enable", rd, 0);
        reg_read(8'h84, rd); check("R1 pending", rd, 0);
        reg_read(8'hC0, rd); check("R1 sync tag", rd, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 engine_reset", {31'b0, engine_reset}, 0);
        check("R12 req_ready", {31'b0, req_ready}, 1);
    endtask

    task automatic t_unmapped;
        reg_read(8'h00, rd); check("R2 unmapped 0x00", rd, 0);
        reg_read(8'h44, rd); check("R2 unmapped 0x44", rd, 0);
        reg_read(8'hF0, rd); check("R2 unmapped 0xF0", rd, 0);
        reg_write(8'h80, 32'hFFFF_FFFF);
        reg_read(8'h80, rd); check("R2 enable readback", rd, 32'hF);
        reg_write(8'h80, 32'h0);
    endtask

    task automatic t_status;
        cmd_room = 8'd5; tx_room = 8'd3; rx_level = 8'd2;
        reg_read(8'hD0, rd); check("R4 cmd room", rd, 5);
        reg_read(8'hD4, rd); check("R4 tx room", rd, 3);
        reg_read(8'hD8, rd); check("R4 rx level", rd, 2);
        rx_level = 8'd0;
    endtask

    task automatic t_push;
        int c0;
        cmd_room = 8'd5; tx_room = 8'd3;
        c0 = cmd_pushes;
        reg_write(8'hE0, 32'hABCD_1234);
        check("R3 cmd push count", cmd_pushes - c0, 1);
        check("R3 cmd push data", {16'b0, last_cmd}, 32'h1234);
        reg_write(8'hE4, 32'hCAFE_F00D);
        check("R3 tx push data", last_tx, 32'hCAFE_F00D);
        cmd_room = 8'd0;
        c0 = cmd_pushes;
        reg_write(8'hE0, 32'h0000_5555);
        check("R3 dropped push", cmd_pushes - c0, 0);
        cmd_room = 8'd5;
        reg_read(8'hD0, rd); check("R3 cmd overflow sticky", rd, 32'h8000_0005);
        tx_room = 8'd0;
        c0 = tx_pushes;
        reg_write(8'hE4, 32'h1);
        check("R3 tx dropped push", tx_pushes - c0, 0);
        reg_read(8'hD4, rd); check("R3 tx overflow", rd, 32'h8000_0000);
        reg_write(8'h40, 32'h1);
        check("R11 engine_reset set", {31'b0, engine_reset}, 1);
        reg_read(8'h40, rd); check("R11 reset readback", rd, 1);
        reg_read(8'hD0, rd); check("R11 overflow cleared", rd, 5);
        reg_read(8'hD4, rd); check("R11 tx overflow cleared", rd, 0);
        reg_write(8'h40, 32'h0);
        check("R11 engine_reset released", {31'b0, engine_reset}, 0);
        cmd_room = 8'd0;
    endtask

    task automatic t_rx;
        int p0;
        rx_level = 8'd3; rx_head = 32'h0000_0100;
        p0 = pops;
        reg_read(8'hEC, rd);
        check("R6 peek data", rd, 32'h100);
        check("R6 peek no pop", pops - p0, 0);
        reg_read(8'hE8, rd);
        check("R5 pop data", rd, 32'h100);
        check("R5 pop count", pops - p0, 1);
        rx_level = 8'd0;
        p0 = pops;
        reg_read(8'hE8, rd);
        check("R5 empty read data", rd, 0);
        check("R5 empty no pop", pops - p0, 0);
        reg_read(8'hEC, rd);
        check("R6 empty peek", rd, 0);
    endtask

    task automatic t_sync;
        @(negedge clk); sync_valid = 1'b1; sync_tag = 8'h5A;
        @(negedge clk); sync_valid = 1'b0;
        reg_read(8'hC0, rd); check("R7 sync tag", rd, 32'h5A);
        reg_read(8'h84, rd); check("R7 pending sync", rd, 32'h8);
        reg_write(8'h84, 32'h8);
        reg_read(8'h84, rd); check("R8 w1c clear", rd, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h84; req_wdata = 32'h8;
        sync_valid = 1'b1; sync_tag = 8'hC3;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; sync_valid = 1'b0;
        reg_read(8'h84, rd); check("R8 sync beats clear", rd, 32'h8);
        reg_write(8'h84, 32'hFF);
        reg_read(8'h84, rd); check("R8 clear all", rd, 0);
    endtask

    task automatic t_level;
        cmd_room = 8'd10;
        idle(1);
        reg_read(8'h84, rd); check("R9 cmd low set", rd, 32'h1);
        reg_write(8'h84, 32'h1);
        reg_read(8'h84, rd); check("R9 re-set while held", rd, 32'h1);
        cmd_room = 8'd2;
        reg_write(8'h84, 32'h1);
        reg_read(8'h84, rd); check("R9 cleared after cond", rd, 0);
        tx_room = 8'd8; rx_level = 8'd9;
        idle(1);
        reg_read(8'h84, rd); check("R9 tx and rx bits", rd, 32'h6);
        tx_room = 8'd0; rx_level = 8'd0;
        reg_write(8'h84, 32'hFF);
        reg_read(8'h84, rd); check("R9 all clear", rd, 0);
    endtask

    task automatic t_irq;
        reg_write(8'h80, 32'h8);
        @(negedge clk); sync_valid = 1'b1; sync_tag = 8'h11;
        @(negedge clk); sync_valid = 1'b0;
        check("R10 irq high", {31'b0, irq}, 1);
        reg_read(8'h88, rd); check("R10 source", rd, 32'h8);
        reg_write(8'h80, 32'h1);
        check("R10 irq masked", {31'b0, irq}, 0);
        reg_read(8'h88, rd); check("R10 source masked", rd, 0);
        reg_read(8'h84, rd); check("R10 pending kept", rd, 32'h8);
        reg_write(8'h84, 32'hFF);
        reg_write(8'h80, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_status();
        t_push();
        t_rx();
        t_sync();
        t_level();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule